// File: doc/BRIEF.md
# Sparse Vector Dot-Product Engine

This block computes the dot product of two sparse vectors that arrive in compressed form. Each operand is a stream of beats. A data beat carries one nonzero value and its coordinate, and data beats come in strictly ascending coordinate order. A closing beat with the `end` flag set marks the end of the segment. The engine steps through both streams together. When the two head coordinates differ, the stream with the lower coordinate is advanced. When they are equal, the engine consumes both heads and passes the pair into a registered multiply stage, which feeds a signed accumulator.

When one stream reaches its closing beat, the engine drains the other stream up to its own closing beat and issues no multiplies while doing so. Once both closing beats are consumed together, the engine presents the accumulated sum and the number of effectual products on a result stream. It holds that result until the result is accepted. It then clears its state for the next segment.

All three interfaces use valid/ready. A beat transfers on a rising edge where valid and ready are both high. Each input ready is combinational and depends on the valids of both input heads. This is legal because valid never depends on ready. A producer must hold valid and data steady until the beat transfers. While a result is pending, both input readies stay low, so result back-pressure stalls both inputs and no beat is lost.

Top module: `sparse_dot`

## Requirements
- R1: An input beat with `end`=1 is a closing beat. Its coordinate and value fields are ignored and never reach the sum.
- R2: When both heads are data beats with different coordinates, only the stream with the lower coordinate is accepted in that cycle, and no product is formed.
- R3: When both heads are data beats with equal coordinates, both are accepted in the same cycle. The signed product of the two values is added to the sum, and the product count rises by one.
- R4: When exactly one head is a closing beat, that beat is held, and the other stream's data beats are accepted one per cycle with no product formed.
- R5: When both heads are closing beats, both are accepted in the same cycle. `o_valid` rises on the next clock edge. `o_sum` then includes every product of the segment, including one formed in the cycle just before.
- R6: A segment that is empty on either input produces `o_sum`=0 and `o_count`=0.
- R7: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_sum` and `o_count` hold steady, and both input readies stay low.
- R8: After the result is accepted, the sum and the count restart from zero for the next segment.
- R9: The sum is signed and `2*VAL_W + clog2(MAX_NZ+1)` bits wide, so `MAX_NZ` products of -2^(VAL_W-1) times -2^(VAL_W-1) are summed exactly.
- R10: After reset, `o_valid` is low and no input beat is accepted until both input valids are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Stream A beat present |
| a_ready | output | 1 | Stream A beat accepted |
| a_end | input | 1 | Stream A closing beat |
| a_coord | input | COORD_W | Stream A coordinate |
| a_val | input | VAL_W | Stream A signed value |
| b_valid | input | 1 | Stream B beat present |
| b_ready | output | 1 | Stream B beat accepted |
| b_end | input | 1 | Stream B closing beat |
| b_coord | input | COORD_W | Stream B coordinate |
| b_val | input | VAL_W | Stream B signed value |
| o_valid | output | 1 | Result present |
| o_ready | input | 1 | Result accepted |
| o_sum | output | 2*VAL_W+clog2(MAX_NZ+1) | Signed dot product |
| o_count | output | clog2(MAX_NZ+1) | Number of effectual products |

## Verification
The last match of a segment can be in the multiply stage on the same edge that both closing beats are accepted. The accumulator update and the segment close therefore coincide. Segments whose final coordinate appears in both operands, some of them fed with no gaps on either input, create exactly that overlap. The bench judges them by comparing the emitted sum with a reference sum computed in the bench by a nested coordinate search. Random result back-pressure is applied at the same time, and on every stalled cycle the bench checks that the result holds steady and that both input readies stay low.

// File: rtl/sxd_pkg.sv
package sxd_pkg;
  typedef enum logic [2:0] {
    ACT_WAIT,
    ACT_ADV_A,
    ACT_ADV_B,
    ACT_MATCH,
    ACT_CLOSE
  } sxd_act_e;
endpackage

// File: rtl/sxd_join.sv
module sxd_join #(
  parameter int COORD_W = 16
) (
  input  logic                 a_ok,
  input  logic                 b_ok,
  input  logic                 a_end,
  input  logic                 b_end,
  input  logic [COORD_W-1:0]   a_coord,
  input  logic [COORD_W-1:0]   b_coord,
  output sxd_pkg::sxd_act_e    act
);
  import sxd_pkg::*;

  // Decide which head(s) to consume; intersection is settled here,
  // before any multiply is issued.
  always_comb begin
    act = ACT_WAIT;
    if (a_ok && b_ok) begin
      if (a_end && b_end)           act = ACT_CLOSE;
      else if (a_end)               act = ACT_ADV_B;   // drain B
      else if (b_end)               act = ACT_ADV_A;   // drain A
      else if (a_coord < b_coord)   act = ACT_ADV_A;
      else if (b_coord < a_coord)   act = ACT_ADV_B;
      else                          act = ACT_MATCH;
    end
  end
endmodule

// File: rtl/sxd_mac.sv
module sxd_mac #(
  parameter int VAL_W  = 16,
  parameter int MAX_NZ = 64,
  localparam int CNT_W = $clog2(MAX_NZ + 1),
  localparam int ACC_W = 2 * VAL_W + CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [VAL_W-1:0]  in_a,
  input  logic signed [VAL_W-1:0]  in_b,
  input  logic                     clear,
  output logic signed [ACC_W-1:0]  acc,
  output logic        [CNT_W-1:0]  cnt
);
  logic                     m_valid;
  logic signed [VAL_W-1:0]  m_a, m_b;
  logic signed [2*VAL_W-1:0] prod;

  // Operand register: the matched pair waits one stage before multiply.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_a     <= '0;
      m_b     <= '0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_a <= in_a;
        m_b <= in_b;
      end
    end
  end

  assign prod = m_a * m_b;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (m_valid) begin
      acc <= acc + ACC_W'(prod);
      cnt <= cnt + 1'b1;
    end
  end

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !clear) |=> (cnt == $past(cnt) + 1'b1));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0 && cnt == '0));

  a_r9_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_NZ));
endmodule

// File: rtl/sparse_dot.sv
module sparse_dot #(
  parameter int COORD_W = 16,
  parameter int VAL_W   = 16,
  parameter int MAX_NZ  = 64,
  localparam int CNT_W  = $clog2(MAX_NZ + 1),
  localparam int ACC_W  = 2 * VAL_W + CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_valid,
  output logic                     a_ready,
  input  logic                     a_end,
  input  logic [COORD_W-1:0]       a_coord,
  input  logic signed [VAL_W-1:0]  a_val,
  input  logic                     b_valid,
  output logic                     b_ready,
  input  logic                     b_end,
  input  logic [COORD_W-1:0]       b_coord,
  input  logic signed [VAL_W-1:0]  b_val,
  output logic                     o_valid,
  input  logic                     o_ready,
  output logic signed [ACC_W-1:0]  o_sum,
  output logic [CNT_W-1:0]         o_count
);
  import sxd_pkg::*;

  logic      holding;
  sxd_act_e  act;
  logic      out_fire;

  sxd_join #(.COORD_W(COORD_W)) i_join (
    .a_ok    (a_valid && !holding),
    .b_ok    (b_valid && !holding),
    .a_end   (a_end),
    .b_end   (b_end),
    .a_coord (a_coord),
    .b_coord (b_coord),
    .act     (act)
  );

  assign a_ready  = (act == ACT_ADV_A) || (act == ACT_MATCH) || (act == ACT_CLOSE);
  assign b_ready  = (act == ACT_ADV_B) || (act == ACT_MATCH) || (act == ACT_CLOSE);
  assign out_fire = holding && o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                  holding <= 1'b0;
    else if (act == ACT_CLOSE)   holding <= 1'b1;
    else if (out_fire)           holding <= 1'b0;
  end

  sxd_mac #(.VAL_W(VAL_W), .MAX_NZ(MAX_NZ)) i_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (act == ACT_MATCH),
    .in_a     (a_val),
    .in_b     (b_val),
    .clear    (out_fire),
    .acc      (o_sum),
    .cnt      (o_count)
  );

  assign o_valid = holding;

  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (!a_ready && !b_ready));

  a_r7_stable_out: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_sum) && $stable(o_count)));

  a_r5_close_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && a_end && b_valid && b_ready && b_end) |=> o_valid);

  a_r3_match_coord: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && b_valid && b_ready && !a_end && !b_end) |-> (a_coord == b_coord));

  a_r2_single_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ready && !b_ready) |-> (!a_end && (b_end || a_coord < b_coord)));

  a_r10_reset_idle: assert property (@(posedge clk)
    $past(!rst_n) |-> !o_valid);
endmodule

// File: tb/test_sparse_dot.sv
module test_sparse_dot;
  localparam int CLK_P  = 10;
  localparam int CW     = 16;
  localparam int VW     = 16;
  localparam int MAXN   = 64;
  localparam int NW     = $clog2(MAXN + 1);
  localparam int AW     = 2 * VW + NW;

  typedef struct packed {
    logic               e;
    logic [CW-1:0]      c;
    logic signed [VW-1:0] v;
  } beat_t;

  logic clk = 0, rst_n = 0;
  logic a_valid = 0, a_end = 0, b_valid = 0, b_end = 0, o_ready = 0;
  logic [CW-1:0] a_coord = 0, b_coord = 0;
  logic signed [VW-1:0] a_val = 0, b_val = 0;
  logic a_ready, b_ready, o_valid;
  logic signed [AW-1:0] o_sum;
  logic [NW-1:0] o_count;

  always #(CLK_P/2) clk = ~clk;

  sparse_dot #(.COORD_W(CW), .VAL_W(VW), .MAX_NZ(MAXN)) i_sparse_dot (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_end(a_end), .a_coord(a_coord), .a_val(a_val),
    .b_valid(b_valid), .b_ready(b_ready), .b_end(b_end), .b_coord(b_coord), .b_val(b_val),
    .o_valid(o_valid), .o_ready(o_ready), .o_sum(o_sum), .o_count(o_count));

  int checks = 0, fails = 0;
  bit done = 0;
  beat_t qa[$], qb[$];
  longint es[$];
  int ec[$];
  string et[$];
  int ta_c[$], tb_c[$];
  int ta_v[$], tb_v[$];
  int gap_a = 3, gap_b = 3;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic beat_t junk_end();
    beat_t b;
    b.e = 1'b1; b.c = CW'($urandom); b.v = VW'($urandom);
    return b;
  endfunction

  // Reference: nested coordinate search over the two lists.
  task automatic seg(string tag);
    longint s = 0;
    int n = 0;
    foreach (ta_c[i]) begin
      beat_t b; b.e = 0; b.c = CW'(ta_c[i]); b.v = VW'(ta_v[i]); qa.push_back(b);
      foreach (tb_c[j]) if (tb_c[j] == ta_c[i]) begin
        s += longint'(ta_v[i]) * longint'(tb_v[j]); n++;
      end
    end
    foreach (tb_c[j]) begin
      beat_t b; b.e = 0; b.c = CW'(tb_c[j]); b.v = VW'(tb_v[j]); qb.push_back(b);
    end
    qa.push_back(junk_end());
    qb.push_back(junk_end());
    es.push_back(s); ec.push_back(n); et.push_back(tag);
    ta_c.delete(); ta_v.delete(); tb_c.delete(); tb_v.delete();
  endtask

  function automatic int nzval();
    int v = int'($signed(16'($urandom)));
    return (v == 0) ? 1 : v;
  endfunction

  task automatic rand_list(bit to_a, int dens);
    for (int c = 0; c < 48; c++) if (($urandom % 100) < dens) begin
      if (to_a) begin ta_c.push_back(c); ta_v.push_back(nzval()); end
      else      begin tb_c.push_back(c); tb_v.push_back(nzval()); end
    end
  endtask

  task automatic drive_a();
    foreach (qa[i]) begin
      bit fired = 0;
      for (int g = 0; g < ($urandom % (gap_a + 1)); g++) begin
        @(negedge clk); a_valid = 0;
      end
      while (!fired) begin
        @(negedge clk);
        a_valid = 1; a_end = qa[i].e; a_coord = qa[i].c; a_val = qa[i].v;
        #(CLK_P/2 - 1);
        fired = a_ready;
      end
    end
    @(negedge clk); a_valid = 0;
  endtask

  task automatic drive_b();
    foreach (qb[i]) begin
      bit fired = 0;
      for (int g = 0; g < ($urandom % (gap_b + 1)); g++) begin
        @(negedge clk); b_valid = 0;
      end
      while (!fired) begin
        @(negedge clk);
        b_valid = 1; b_end = qb[i].e; b_coord = qb[i].c; b_val = qb[i].v;
        #(CLK_P/2 - 1);
        fired = b_ready;
      end
    end
    @(negedge clk); b_valid = 0;
  endtask

  task automatic consume();
    int k = 0;
    bit stalled = 0;
    longint ps = 0;
    int pc = 0;
    while (k < es.size()) begin
      @(negedge clk);
      o_ready = ($urandom % 4) != 0;
      #(CLK_P/2 - 1);
      if (o_valid) begin
        check(!a_ready && !b_ready, "R7", "input ready during pending result", a_ready, 0);
        if (stalled) begin
          check(o_sum == ps, "R7", "sum moved under stall", o_sum, ps);
          check(o_count == pc, "R7", "count moved under stall", o_count, pc);
        end
      end
      if (o_valid && o_ready) begin
        check(o_sum == es[k], et[k], "sum", o_sum, es[k]);
        check(int'(o_count) == ec[k], et[k], "count", o_count, ec[k]);
        k++;
      end
      stalled = o_valid && !o_ready;
      ps = o_sum; pc = int'(o_count);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R6: both empty, A empty, B empty
    seg("R6");
    tb_c = '{1, 4}; tb_v = '{5, 7}; seg("R6/R4");
    ta_c = '{2, 3}; ta_v = '{-3, 9}; seg("R6/R4");
    // R2: interleaved, never equal
    ta_c = '{1, 3, 5}; ta_v = '{2, 2, 2}; tb_c = '{2, 4, 6}; tb_v = '{3, 3, 3}; seg("R2");
    // R3: identical coordinates, signed values
    ta_c = '{0, 7, 9}; ta_v = '{-4, 6, 100}; tb_c = '{0, 7, 9}; tb_v = '{5, -6, 3}; seg("R3");
    // R5: last coordinate shared, product lands as segment closes
    ta_c = '{2, 9}; ta_v = '{11, -13}; tb_c = '{5, 9}; tb_v = '{1, 17}; seg("R5");
    // R4: A ends early, long drain of B
    ta_c = '{1}; ta_v = '{8};
    for (int c = 1; c < 12; c++) begin tb_c.push_back(c); tb_v.push_back(c); end
    seg("R4");
    // R9: full segment of most-negative products
    for (int c = 0; c < MAXN; c++) begin
      ta_c.push_back(c); ta_v.push_back(-32768); tb_c.push_back(c); tb_v.push_back(-32768);
    end
    seg("R9");
    // R1: closing beats carry junk (every segment does); values chosen to expose leakage
    ta_c = '{3}; ta_v = '{1}; tb_c = '{3}; tb_v = '{1}; seg("R1");
    // R8: random segments back to back
    for (int s = 0; s < 30; s++) begin
      rand_list(1, 20 + int'($urandom % 60));
      rand_list(0, 20 + int'($urandom % 60));
      seg("R8/R3/R2");
    end

    repeat (3) @(negedge clk);
    rst_n = 1;
    #(CLK_P/2 - 1);
    check(!o_valid, "R10", "o_valid after reset", o_valid, 0);
    check(!a_ready && !b_ready, "R10", "ready with no valid", a_ready | b_ready, 0);

    fork
      drive_a();
      drive_b();
      consume();
    join

    // Back-to-back phase: no input gaps, shared last coordinates
    gap_a = 0; gap_b = 0;
    qa.delete(); qb.delete(); es.delete(); ec.delete(); et.delete();
    for (int s = 0; s < 6; s++) begin
      rand_list(1, 50); rand_list(0, 50);
      ta_c.push_back(50); ta_v.push_back(nzval());
      tb_c.push_back(50); tb_v.push_back(nzval());
      seg("R5/R8");
    end
    fork
      drive_a();
      drive_b();
      consume();
    join

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule